// File: doc/BRIEF.md
# Word-serial GF(2^m) Montgomery multiplier

This block multiplies two elements of the binary field GF(2^m) in polynomial basis and returns their Montgomery product c(x) = a(x)·b(x)·x^(-m) mod p(x). The modulus p(x) is supplied at run time without its leading x^m term. Field addition is a plain XOR, so no carries propagate between coefficient positions anywhere in the datapath.

The m-bit operand a is cut into s = m/w words of w bits. On a start strobe the block latches a, b and p. In the next cycle it derives the constant P0' = P0^(-1) mod x^w from the low word of p. It then runs s iterations, one per clock, and each one consumes one word of a starting from the least significant. Every iteration adds A_i·b and a multiple M·p of the modulus to the accumulator, where M is chosen so that the lowest w bits cancel. The accumulator is then shifted right by one word. When the last iteration finishes, the result is written to c_o and done_o pulses for one cycle. Operands held in Montgomery form, x·x^m mod p, keep that form through the multiply, so a surrounding elliptic-curve engine can chain multiplies without converting between them.

Top module: `gf2m_mont_mul`

## Requirements
- R1: When an operation completes, c_o equals a·b·x^(-m) mod p as a fully reduced m-bit polynomial. This holds for every word width w that divides m (checked at m = 8 with w = 1, 2 and 4).
- R2: Bit i of a_i, b_i, p_i and c_o is the coefficient of x^i. p_i carries p_(m-1)..p_0, the x^m term is implicit, and p_0 must be 1.
- R3: When the block is idle and start_i is high at a rising edge, an operation begins. done_o is high after exactly the (s+1)-th rising edge that follows: one cycle for the constant and s cycles of iteration.
- R4: If start_i is high while an operation is running, it has no effect. The running operation keeps its result and its completion cycle.
- R5: Reset clears c_o and done_o to 0. c_o changes only in the cycle where done_o rises, and it holds its value through idle time and through the next operation until that operation completes.
- R6: In every iteration, the lowest w bits of c + A_i·b + M·p are zero, so the one-word shift drops no coefficient.
- R7: When b equals x^m mod p, which is the low m bits of p_i, the result equals a.
- R8: When either operand is zero, the result is zero.
- R9: done_o is high for exactly one cycle per operation.
- R10: Operands are sampled only at the accepted start. Changes to a_i, b_i or p_i after that edge do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| a_i | input | M | Multiplicand a(x) |
| b_i | input | M | Multiplier b(x) |
| p_i | input | M | Modulus p(x) without its x^M term |
| c_o | output | M | Montgomery product, held until the next completion |
| done_o | output | 1 | One-cycle pulse when c_o is updated |

## Verification
The assertions check four things on every clock. Each iteration's sum must have a zero low word, which confirms that the derived inverse constant is correct. done_o must be a single-cycle pulse. c_o must move only together with done_o. A start must either enter the constant phase from idle or be dropped while busy. The arithmetic value itself can only be shown by the bench scenarios. These compare three word widths against a bit-serial shift-and-reduce reference across directed corners (identity multiplier, zero operands, x^m + 1 modulus) and seeded random operands and moduli. The bench also measures the exact completion cycle and injects a start plus operand changes in the middle of a running operation.

// File: rtl/gf2m_mont_pkg.sv
package gf2m_mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } mm_state_e;
endpackage

// File: rtl/gf2m_word_inv.sv
// Inverse of a w-bit polynomial with constant term 1, modulo x^w.
module gf2m_word_inv #(
  parameter int W = 2
) (
  input  logic [W-1:0] p_lo_i,
  output logic [W-1:0] inv_o
);
  always_comb begin
    logic acc;
    inv_o    = '0;
    inv_o[0] = 1'b1;
    for (int i = 1; i < W; i++) begin
      // coefficient i of p_lo*inv must vanish; p_lo[0] = 1
      acc = 1'b0;
      for (int j = 1; j <= i; j++) acc ^= p_lo_i[j] & inv_o[i-j];
      inv_o[i] = acc;
    end
  end
endmodule

// File: rtl/gf2m_mont_step.sv
// One word iteration: c' = (c + A_i*b + M*p) / x^W.
module gf2m_mont_step #(
  parameter int M = 8,
  parameter int W = 2
) (
  input  logic [M-1:0] c_i,
  input  logic [W-1:0] a_word_i,
  input  logic [M-1:0] b_i,
  input  logic [M:0]   p_i,
  input  logic [W-1:0] pinv_i,
  output logic [M-1:0] c_o,
  output logic [W-1:0] low_o
);
  localparam int TW = M + W;

  logic [TW-1:0] ab_pp [W];
  logic [TW-1:0] qp_pp [W];
  logic [TW-1:0] t_sum;
  logic [TW-1:0] u_sum;
  logic [W-1:0]  q;

  for (genvar j = 0; j < W; j++) begin : g_pp
    assign ab_pp[j] = a_word_i[j] ? (TW'(b_i) << j) : '0;
    assign qp_pp[j] = q[j]        ? (TW'(p_i) << j) : '0;
  end

  always_comb begin
    t_sum = TW'(c_i);
    for (int j = 0; j < W; j++) t_sum ^= ab_pp[j];
  end

  always_comb begin
    q = '0;
    for (int j = 0; j < W; j++)
      if (pinv_i[j]) q ^= t_sum[W-1:0] << j;
  end

  always_comb begin
    u_sum = t_sum;
    for (int j = 0; j < W; j++) u_sum ^= qp_pp[j];
  end

  assign c_o   = u_sum[TW-1:W];
  assign low_o = u_sum[W-1:0];
endmodule

// File: rtl/gf2m_mont_mul.sv
module gf2m_mont_mul
  import gf2m_mont_pkg::*;
#(
  parameter int M = 8,
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] p_i,
  output logic [M-1:0] c_o,
  output logic         done_o
);
  localparam int S  = M / W;
  localparam int CW = (S > 1) ? $clog2(S) : 1;

  mm_state_e      state_q;
  logic [M-1:0]   a_q, b_q, p_q, acc_q;
  logic [W-1:0]   pinv_q, pinv_w, low_w;
  logic [M-1:0]   step_c;
  logic [CW-1:0]  cnt_q;

  gf2m_word_inv #(.W(W)) u_inv (
    .p_lo_i (p_q[W-1:0]),
    .inv_o  (pinv_w)
  );

  gf2m_mont_step #(.M(M), .W(W)) u_step (
    .c_i      (acc_q),
    .a_word_i (a_q[W-1:0]),
    .b_i      (b_q),
    .p_i      ({1'b1, p_q}),
    .pinv_i   (pinv_q),
    .c_o      (step_c),
    .low_o    (low_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      p_q     <= '0;
      acc_q   <= '0;
      pinv_q  <= '0;
      cnt_q   <= '0;
      c_o     <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          a_q     <= a_i;
          b_q     <= b_i;
          p_q     <= p_i;
          acc_q   <= '0;
          cnt_q   <= '0;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          pinv_q  <= pinv_w;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          acc_q <= step_c;
          a_q   <= a_q >> W;
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(S - 1)) begin
            c_o     <= step_c;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_start_enters_prep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_PREP));

  a_r4_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_PREP));

  a_r5_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_o || $stable(c_o)));

  a_r6_low_word_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (low_w == '0));

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_gf2m_mont_mul.sv
`timescale 1ns/1ps
module tb_gf2m_mont_mul;
  localparam int M = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] a_in = '0, b_in = '0, p_in = 8'h1B;
  logic [M-1:0] c_w2, c_w1, c_w4;
  logic         d_w2, d_w1, d_w4;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gf2m_mont_mul #(.M(M), .W(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a_in), .b_i(b_in), .p_i(p_in), .c_o(c_w2), .done_o(d_w2));
  gf2m_mont_mul #(.M(M), .W(1)) dut_w1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a_in), .b_i(b_in), .p_i(p_in), .c_o(c_w1), .done_o(d_w1));
  gf2m_mont_mul #(.M(M), .W(4)) dut_w4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a_in), .b_i(b_in), .p_i(p_in), .c_o(c_w4), .done_o(d_w4));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-serial reference: full product mod p, then m divisions by x
  function automatic logic [M-1:0] mont_ref(input logic [M-1:0] a, b, p);
    logic [M:0] pf = {1'b1, p};
    logic [M:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r ^= pf;
      if (b[i]) r ^= {1'b0, a};
    end
    for (int i = 0; i < M; i++) begin
      if (r[0]) r ^= pf;
      r = r >> 1;
    end
    return r[M-1:0];
  endfunction

  logic [M-1:0] last_c = '0;

  task automatic run_op(input logic [M-1:0] a, b, p, input bit glitch, input string req);
    logic [M-1:0] exp = mont_ref(a, b, p);
    int k2 = 0, k1 = 0, k4 = 0, n2 = 0, n1 = 0, n4 = 0;
    @(negedge clk);
    a_in = a; b_in = b; p_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5: previous result still held after start
    check(c_w2 == last_c && c_w1 == last_c && c_w4 == last_c, "R5 hold during op", c_w2, last_c);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (d_w2) begin n2++; if (k2 == 0) k2 = k; end
      if (d_w1) begin n1++; if (k1 == 0) k1 = k; end
      if (d_w4) begin n4++; if (k4 == 0) k4 = k; end
      if (glitch && k == 1) begin
        start = 1'b1; a_in = ~a; b_in = b ^ 8'h5A; p_in = p ^ 8'h60;
      end
      if (glitch && k == 2) start = 1'b0;
    end
    check(c_w2 == exp, {req, " w2"}, c_w2, exp);
    check(c_w1 == exp, {req, " w1"}, c_w1, exp);
    check(c_w4 == exp, {req, " w4"}, c_w4, exp);
    check(k2 == 5 && k1 == 9 && k4 == 3, "R3 done latency", (k1 << 8) | (k2 << 4) | k4, 32'h953);
    check(n2 == 1 && n1 == 1 && n4 == 1, "R9 single done pulse", (n1 << 8) | (n2 << 4) | n4, 32'h111);
    last_c = exp;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(c_w2 == 0 && c_w1 == 0 && c_w4 == 0, "R5 reset c_o", c_w2, 0);
    check(!d_w2 && !d_w1 && !d_w4, "R5 reset done_o", d_w2, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(8'h53, 8'hCA, 8'h1B, 1'b0, "R1 R2 directed");
    run_op(8'h5C, 8'h1B, 8'h1B, 1'b0, "R7 identity multiplier");
    run_op(8'hE7, 8'h0D, 8'h0D, 1'b0, "R7 identity other p");
    run_op(8'h00, 8'hA5, 8'h1B, 1'b0, "R8 zero a");
    run_op(8'h3C, 8'h00, 8'h1B, 1'b0, "R8 zero b");
    run_op(8'hFF, 8'hFF, 8'h01, 1'b0, "R1 p=x^8+1");
    run_op(8'h80, 8'h80, 8'hFF, 1'b0, "R1 top coefficients");
    run_op(8'hA7, 8'h39, 8'h1B, 1'b1, "R4 R10 start and operands changed while busy");

    // R5: input changes without start leave c_o alone
    a_in = 8'h11; b_in = 8'h22; p_in = 8'h33;
    repeat (6) @(negedge clk);
    check(c_w2 == last_c && c_w1 == last_c && c_w4 == last_c, "R5 idle hold", c_w1, last_c);

    for (int n = 0; n < 40; n++) begin
      logic [M-1:0] ra = M'($urandom);
      logic [M-1:0] rb = M'($urandom);
      logic [M-1:0] rp = M'($urandom) | 8'h01;
      run_op(ra, rb, rp, (n % 9) == 4, "R1 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule